// File: doc/BRIEF.md
# SMBus Special-Address and Alert Line Controller

This block sits next to an I2C byte engine and handles the two SMBus addresses with a fixed meaning, and the shared alert wire. When the byte engine has captured a 7-bit address, it raises an address-valid strobe. The block then answers at once, from combinational logic, whether that address should be acknowledged. In host mode the Host Notify address `0b0001000` is accepted. In device mode with alerts enabled, the Alert Response Address `0b0001100` is accepted. No other address is accepted by this block, and the read/write bit is never part of the compare.

In device mode, enabling alerts pulls the open-drain alert wire low through a drive-enable output, and it arms the Alert Response match at the same time. In host mode, the block watches the alert wire through a two-stage synchronizer. A high-to-low transition of the masked line sets a sticky flag. The flag stays set until software sends a one-cycle clear pulse. An interrupt follows the flag when the error-interrupt enable is set. Clearing alerts makes the block treat the wire as high, whatever the pin level.

Top module: `smba_ctrl`

## Requirements
- R1: With `host_mode`=1 and `addr_valid`=1, an `rx_addr` of 7'h08 gives `addr_ack`=1 in the same cycle.
- R2: 7'h08 is never acknowledged when `host_mode`=0. 7'h0C is never acknowledged when `host_mode`=1.
- R3: `alert_drive_low` is 1 exactly when `host_mode`=0 and `alert_en`=1. Otherwise the wire is released.
- R4: 7'h0C is acknowledged (with `addr_valid`=1) only when `host_mode`=0 and `alert_en`=1, which is exactly when the block drives the wire low.
- R5: `addr_ack` is 0 while `addr_valid`=0. It is 0 for every address other than 7'h08 and 7'h0C.
- R6: With `host_mode`=1 and `alert_en`=1, `alert_pin_in` going low sets `alert_flag` after the third rising clock edge counted from the change, and not before.
- R7: `alert_flag` stays set, even after the pin returns high, until a one-cycle `flag_clr`=1. The flag reads 0 after that edge.
- R8: When a falling edge and `flag_clr` land on the same edge, the flag stays 1.
- R9: When `alert_en`=0 or `host_mode`=0, the internal line is taken as high. A low pin then never sets the flag. Enabling monitoring while the pin is already low counts as a falling edge.
- R10: `irq` equals `alert_flag` AND `err_irq_en`.
- R11: After reset, `addr_ack`, `alert_flag` and `irq` are 0. `alert_drive_low` follows R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_mode | input | 1 | 1 = SMBus host, 0 = device |
| alert_en | input | 1 | Alert enable (drive in device mode, monitor in host mode) |
| err_irq_en | input | 1 | Interrupt enable for the alert flag |
| addr_valid | input | 1 | Strobe: rx_addr holds a received address |
| rx_addr | input | 7 | Received 7-bit address, without the R/W bit |
| flag_clr | input | 1 | One-cycle write-1-to-clear of the alert flag |
| alert_pin_in | input | 1 | Raw level of the alert wire |
| addr_ack | output | 1 | Acknowledge decision for rx_addr |
| alert_drive_low | output | 1 | Open-drain pull-down enable for the alert wire |
| alert_flag | output | 1 | Sticky alert-seen flag |
| irq | output | 1 | Alert interrupt |

## Verification
`addr_ack` and `alert_drive_low` are combinational. The bench therefore sets the inputs and checks these outputs in the same cycle, half a period later, with no clock edge in between. The flag path has three registers: two synchronizer stages and the flag itself. Pin changes are driven on a falling clock edge. The flag is checked as still clear after the second rising edge and as set after the third. A clear pulse takes effect on the first rising edge, and `irq` is combinational from the flag. Every sample is taken on a falling clock edge.

// File: rtl/smba_pkg.sv
package smba_pkg;
  localparam int unsigned SMBA_ADDR_W = 7;
  localparam logic [SMBA_ADDR_W-1:0] SMBA_HOST_NOTIFY_ADDR = 7'b0001000;
  localparam logic [SMBA_ADDR_W-1:0] SMBA_ALERT_RESP_ADDR  = 7'b0001100;
endpackage

// File: rtl/smba_sync.sv
module smba_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb stage_d = din;
    end else begin : g_chain
      always_comb stage_d = {stage_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= {STAGES{RESET_VAL}};
    else        stage_q <= stage_d;
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/smba_addr_match.sv
module smba_addr_match #(
  parameter int unsigned           ADDR_W   = smba_pkg::SMBA_ADDR_W,
  parameter logic [ADDR_W-1:0]     HN_ADDR  = smba_pkg::SMBA_HOST_NOTIFY_ADDR,
  parameter logic [ADDR_W-1:0]     ARA_ADDR = smba_pkg::SMBA_ALERT_RESP_ADDR
) (
  input  logic              host_mode,
  input  logic              ara_armed,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] rx_addr,
  output logic              ack
);
  logic hn_hit;
  logic ara_hit;

  always_comb begin
    hn_hit  = (rx_addr == HN_ADDR)  && host_mode;
    ara_hit = (rx_addr == ARA_ADDR) && !host_mode && ara_armed;
    ack     = addr_valid && (hn_hit || ara_hit);
  end
endmodule

// File: rtl/smba_alert_mon.sv
module smba_alert_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic monitor_en,
  input  logic line_sync,
  input  logic flag_clr,
  output logic flag
);
  logic line_int;
  logic prev_q, prev_d;
  logic flag_q, flag_d;
  logic fall;

  always_comb begin
    line_int = monitor_en ? line_sync : 1'b1;
    fall     = prev_q && !line_int;
    prev_d   = line_int;
    flag_d   = fall || (flag_q && !flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q); // R7
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && flag_clr) |=> flag_q); // R8
  AST_FLAG_NEEDS_MON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(monitor_en)); // R9
endmodule

// File: rtl/smba_ctrl.sv
module smba_ctrl #(
  parameter int unsigned ADDR_W      = smba_pkg::SMBA_ADDR_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_mode,
  input  logic              alert_en,
  input  logic              err_irq_en,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic              flag_clr,
  input  logic              alert_pin_in,
  output logic              addr_ack,
  output logic              alert_drive_low,
  output logic              alert_flag,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] ARA_ADDR = smba_pkg::SMBA_ALERT_RESP_ADDR;

  logic rst_sync_n;
  logic pin_sync;
  logic drive_en;
  logic monitor_en;

  smba_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .din(1'b1), .dout(rst_sync_n)
  );

  smba_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_sync_n), .din(alert_pin_in), .dout(pin_sync)
  );

  always_comb begin
    drive_en   = !host_mode && alert_en;
    monitor_en = host_mode && alert_en;
  end

  smba_addr_match #(.ADDR_W(ADDR_W)) u_match (
    .host_mode (host_mode),
    .ara_armed (drive_en),
    .addr_valid(addr_valid),
    .rx_addr   (rx_addr),
    .ack       (addr_ack)
  );

  smba_alert_mon u_mon (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .monitor_en(monitor_en),
    .line_sync (pin_sync),
    .flag_clr  (flag_clr),
    .flag      (alert_flag)
  );

  assign alert_drive_low = drive_en;
  assign irq             = alert_flag && err_irq_en;

  AST_ACK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !addr_valid |-> !addr_ack); // R5
  AST_ARA_ONLY_WHEN_DRIVING: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr_ack && rx_addr == ARA_ADDR) |-> alert_drive_low); // R4
  AST_HOST_RELEASES_LINE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    host_mode |-> !alert_drive_low); // R3
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (alert_flag && err_irq_en)); // R10
endmodule

// File: tb/tb_smba_ctrl.sv
module tb_smba_ctrl;
  logic clk = 1'b0;
  logic rst_n;
  logic host_mode, alert_en, err_irq_en, addr_valid, flag_clr, alert_pin_in;
  logic [6:0] rx_addr;
  logic addr_ack, alert_drive_low, alert_flag, irq;
  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  smba_ctrl dut (
    .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .alert_en(alert_en),
    .err_irq_en(err_irq_en), .addr_valid(addr_valid), .rx_addr(rx_addr),
    .flag_clr(flag_clr), .alert_pin_in(alert_pin_in), .addr_ack(addr_ack),
    .alert_drive_low(alert_drive_low), .alert_flag(alert_flag), .irq(irq)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_mode = 1'b1; alert_en = 1'b0; err_irq_en = 1'b0;
    addr_valid = 1'b0; flag_clr = 1'b0; alert_pin_in = 1'b1; rx_addr = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    // R11 reset state
    chk("R11 ack", addr_ack, 1'b0);
    chk("R11 drive", alert_drive_low, 1'b0);
    chk("R11 flag", alert_flag, 1'b0);
    chk("R11 irq", irq, 1'b0);

    // Exhaustive address sweep: R1 R2 R3 R4 R5
    for (int hm = 0; hm < 2; hm++)
      for (int en = 0; en < 2; en++)
        for (int v = 0; v < 2; v++)
          for (int a = 0; a < 128; a++) begin
            logic exp_ack;
            host_mode = hm[0]; alert_en = en[0]; addr_valid = v[0]; rx_addr = a[6:0];
            #1;
            exp_ack = v[0] && ((hm[0] && a == 8) || (!hm[0] && en[0] && a == 12));
            if (a == 8 && hm == 1)      chk("R1 host notify ack", addr_ack, exp_ack);
            else if (a == 8 || a == 12 && hm == 1) chk("R2 mode gate", addr_ack, exp_ack);
            else if (a == 12)           chk("R4 alert response ack", addr_ack, exp_ack);
            else                        chk("R5 other/invalid", addr_ack, exp_ack);
            chk("R3 drive", alert_drive_low, !hm[0] && en[0]);
          end
    addr_valid = 1'b0;
    cyc(1);

    // R9: masked pin does not set flag (host, alert_en=0; device, alert_en=1)
    host_mode = 1'b1; alert_en = 1'b0;
    alert_pin_in = 1'b0; cyc(6);
    chk("R9 masked host", alert_flag, 1'b0);
    host_mode = 1'b0; alert_en = 1'b1; cyc(6);
    chk("R9 device mode", alert_flag, 1'b0);
    alert_pin_in = 1'b1; alert_en = 1'b0; host_mode = 1'b1; cyc(4);

    // R6: falling edge timing
    alert_en = 1'b1; cyc(4);
    alert_pin_in = 1'b0;
    cyc(2);
    chk("R6 not before 3rd edge", alert_flag, 1'b0);
    cyc(1);
    chk("R6 set on 3rd edge", alert_flag, 1'b1);
    // R10 irq gating
    err_irq_en = 1'b0; #1;
    chk("R10 irq off", irq, 1'b0);
    err_irq_en = 1'b1; #1;
    chk("R10 irq on", irq, 1'b1);

    // R7 sticky, then clear
    alert_pin_in = 1'b1; cyc(5);
    chk("R7 sticky", alert_flag, 1'b1);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    chk("R7 cleared", alert_flag, 1'b0);
    chk("R10 irq follows clear", irq, 1'b0);

    // R8 set wins over clear
    alert_pin_in = 1'b0; cyc(3);
    chk("R8 setup", alert_flag, 1'b1);
    alert_pin_in = 1'b1; cyc(4);
    alert_pin_in = 1'b0; cyc(2);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    chk("R8 set beats clear", alert_flag, 1'b1);
    flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    chk("R7 clear with pin held low", alert_flag, 1'b0);
    cyc(4);
    chk("R7 no re-set while low", alert_flag, 1'b0);

    // R9: enabling while pin low counts as edge
    alert_en = 1'b0; cyc(3);
    alert_en = 1'b1; cyc(1);
    chk("R9 enable with pin low", alert_flag, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule